// File: doc/BRIEF.md
# Variable-length instruction fetch decoder

This block is the field splitter of a fetch stage for a small 64-bit stack-machine instruction set. Each cycle it is given the current program counter and a ten-byte window of instruction memory. The window's first byte sits at that address. From this it extracts the opcode, the function or condition code, up to two register specifiers and an optional eight-byte constant. It also reports which optional parts are present, whether the encoding is legal, the fall-through address of the next instruction and a status code.

The opcode nibble alone settles the instruction length, which is 1, 2, 9 or 10 bytes, and where each field lies. The constant is assembled least-significant byte first. The block is purely combinational, so the results are meant to be captured by the pipeline register that follows it.

Top module: `fetch_decode`

## Requirements
- R1: `icode` is bits 7:4 of window byte 0 and `ifun` is bits 3:0 of window byte 0, for every input. Window byte k occupies `fetch_win[8k+7:8k]` and is the byte at address pc+k.
- R2: `instr_valid` is 1 exactly when the following holds. `icode` is 0x0 to 0xB. `ifun` is at most 6 when `icode` is 0x2 (conditional move) or 0x7 (jump). `ifun` is at most 3 when `icode` is 0x6 (ALU op). `ifun` is 0 for every other `icode` in that range.
- R3: For a valid instruction, `need_regids` is 1 for icode 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB. `need_valC` is 1 for icode 0x3, 0x4, 0x5, 0x7 and 0x8. Both flags are 0 for an invalid instruction.
- R4: When `need_regids` is 1, `rA` is bits 7:4 and `rB` is bits 3:0 of window byte 1, except that `rB` is 0xF for push (0xA) and pop (0xB). When `need_regids` is 0, both are 0xF.
- R5: When `need_valC` is 1, `valC` is the eight bytes that start at window byte 2 (with a register byte) or at window byte 1 (without one), taken lowest byte first. Otherwise `valC` is 0.
- R6: For a valid instruction, `valP` = `pc_in` + 1 + `need_regids` + 8·`need_valC`, modulo 2^64. The lengths are 1 (halt, nop, ret), 2 (cmov, ALU op, push, pop), 9 (jump, call) and 10 (irmovq, rmmovq, mrmovq).
- R7: `stat` is 2 (halt) for a valid halt byte 0x00, 4 (illegal instruction) when `instr_valid` is 0, and 1 (normal) otherwise.
- R8: For an invalid instruction, `rA` and `rB` are 0xF, `valC` is 0 and `valP` equals `pc_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_in | input | 64 | Address of the first window byte |
| fetch_win | input | 80 | Instruction bytes; byte k at bits 8k+7:8k |
| icode | output | 4 | Opcode nibble |
| ifun | output | 4 | Function / condition nibble |
| rA | output | 4 | First register specifier, 0xF when absent |
| rB | output | 4 | Second register specifier, 0xF when absent |
| valC | output | 64 | Little-endian constant, 0 when absent |
| valP | output | 64 | Fall-through next address |
| need_regids | output | 1 | Register byte present |
| need_valC | output | 1 | Constant present |
| instr_valid | output | 1 | Legal opcode and function |
| stat | output | 3 | 1 normal, 2 halt, 4 illegal |

## Verification
No register lies between the inputs and any output, so every result is due in the same cycle in which its window and PC are applied. The bench changes the inputs just after a rising edge and compares all outputs at the following falling edge, half a period later. No result depends on the order of processes at an edge. The sweep covers every first byte, several register bytes and constants, and PCs near the top of the address space.

// File: rtl/fd_pkg.sv
package fd_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;

  localparam logic [3:0] OP_HALT  = 4'h0;
  localparam logic [3:0] OP_NOP   = 4'h1;
  localparam logic [3:0] OP_CMOV  = 4'h2;
  localparam logic [3:0] OP_IRMOV = 4'h3;
  localparam logic [3:0] OP_RMMOV = 4'h4;
  localparam logic [3:0] OP_MRMOV = 4'h5;
  localparam logic [3:0] OP_ALU   = 4'h6;
  localparam logic [3:0] OP_JMP   = 4'h7;
  localparam logic [3:0] OP_CALL  = 4'h8;
  localparam logic [3:0] OP_RET   = 4'h9;
  localparam logic [3:0] OP_PUSH  = 4'hA;
  localparam logic [3:0] OP_POP   = 4'hB;

  localparam logic [3:0] NO_REG = 4'hF;

  localparam logic [2:0] ST_AOK = 3'd1;
  localparam logic [2:0] ST_HLT = 3'd2;
  localparam logic [2:0] ST_ADR = 3'd3;
  localparam logic [2:0] ST_INS = 3'd4;

  // Largest function nibble accepted per opcode; 4'hF marks an illegal opcode.
  function automatic logic [3:0] ifun_limit(input logic [3:0] op);
    case (op)
      OP_CMOV, OP_JMP: ifun_limit = 4'd6;
      OP_ALU:          ifun_limit = 4'd3;
      OP_HALT, OP_NOP, OP_IRMOV, OP_RMMOV, OP_MRMOV,
      OP_CALL, OP_RET, OP_PUSH, OP_POP: ifun_limit = 4'd0;
      default:         ifun_limit = 4'hF;
    endcase
  endfunction

  // Byte count of an instruction from its optional parts.
  function automatic int unsigned byte_count(input logic has_regs,
                                             input logic has_const,
                                             input int unsigned const_bytes);
    byte_count = 1 + (has_regs ? 1 : 0) + (has_const ? const_bytes : 0);
  endfunction
endpackage

// File: rtl/fd_class.sv
module fd_class
  import fd_pkg::*;
(
  input  logic [3:0] icode_i,
  input  logic [3:0] ifun_i,
  output logic       valid_o,
  output logic       need_regs_o,
  output logic       need_const_o,
  output logic       is_halt_o,
  output logic       is_stack_o
);
  logic [3:0] limit;
  logic       regs_raw;
  logic       const_raw;

  assign limit   = ifun_limit(icode_i);
  assign valid_o = (limit != 4'hF) && (ifun_i <= limit);

  always_comb begin
    regs_raw  = 1'b0;
    const_raw = 1'b0;
    case (icode_i)
      OP_CMOV, OP_ALU, OP_PUSH, OP_POP: regs_raw = 1'b1;
      OP_IRMOV, OP_RMMOV, OP_MRMOV: begin
        regs_raw  = 1'b1;
        const_raw = 1'b1;
      end
      OP_JMP, OP_CALL: const_raw = 1'b1;
      default: begin
        regs_raw  = 1'b0;
        const_raw = 1'b0;
      end
    endcase
  end

  assign need_regs_o  = valid_o & regs_raw;
  assign need_const_o = valid_o & const_raw;
  assign is_halt_o    = valid_o & (icode_i == OP_HALT);
  assign is_stack_o   = (icode_i == OP_PUSH) || (icode_i == OP_POP);
endmodule

// File: rtl/fd_fields.sv
module fd_fields
  import fd_pkg::*;
#(
  parameter int CONST_BYTES = 8,
  localparam int WIN_BYTES  = CONST_BYTES + 2,
  localparam int WIN_W      = WIN_BYTES * BYTE_W,
  localparam int CONST_W    = CONST_BYTES * BYTE_W
) (
  input  logic [WIN_W-1:0]   win_i,
  input  logic               need_regs_i,
  input  logic               need_const_i,
  input  logic               is_stack_i,
  output logic [NIB_W-1:0]   ra_o,
  output logic [NIB_W-1:0]   rb_o,
  output logic [CONST_W-1:0] const_o
);
  logic [BYTE_W-1:0] reg_byte;
  assign reg_byte = win_i[BYTE_W +: BYTE_W];

  assign ra_o = need_regs_i ? reg_byte[7:4] : NO_REG;
  assign rb_o = (need_regs_i && !is_stack_i) ? reg_byte[3:0] : NO_REG;

  // Constant bytes start one byte later when a register byte is present.
  for (genvar gb = 0; gb < CONST_BYTES; gb++) begin : g_const_byte
    logic [BYTE_W-1:0] after_regs;
    logic [BYTE_W-1:0] after_op;
    assign after_regs = win_i[(gb + 2) * BYTE_W +: BYTE_W];
    assign after_op   = win_i[(gb + 1) * BYTE_W +: BYTE_W];
    assign const_o[gb * BYTE_W +: BYTE_W] =
      !need_const_i ? '0 : (need_regs_i ? after_regs : after_op);
  end
endmodule

// File: rtl/fd_nextpc.sv
module fd_nextpc
  import fd_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int CONST_BYTES = 8
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              valid_i,
  input  logic              need_regs_i,
  input  logic              need_const_i,
  output logic [ADDR_W-1:0] next_o
);
  function automatic logic [ADDR_W-1:0] step(input logic r, input logic c);
    int unsigned n;
    n = byte_count(r, c, CONST_BYTES);
    step = ADDR_W'(n);
  endfunction

  assign next_o = valid_i ? (pc_i + step(need_regs_i, need_const_i)) : pc_i;
endmodule

// File: rtl/fetch_decode.sv
module fetch_decode
  import fd_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int CONST_BYTES = 8,
  localparam int WIN_W      = (CONST_BYTES + 2) * BYTE_W,
  localparam int CONST_W    = CONST_BYTES * BYTE_W
) (
  input  logic [ADDR_W-1:0]  pc_in,
  input  logic [WIN_W-1:0]   fetch_win,
  output logic [3:0]         icode,
  output logic [3:0]         ifun,
  output logic [3:0]         rA,
  output logic [3:0]         rB,
  output logic [CONST_W-1:0] valC,
  output logic [ADDR_W-1:0]  valP,
  output logic               need_regids,
  output logic               need_valC,
  output logic               instr_valid,
  output logic [2:0]         stat
);
  logic halt_seen;
  logic stack_op;

  assign icode = fetch_win[7:4];
  assign ifun  = fetch_win[3:0];

  fd_class u_class (
    .icode_i      (icode),
    .ifun_i       (ifun),
    .valid_o      (instr_valid),
    .need_regs_o  (need_regids),
    .need_const_o (need_valC),
    .is_halt_o    (halt_seen),
    .is_stack_o   (stack_op)
  );

  fd_fields #(.CONST_BYTES(CONST_BYTES)) u_fields (
    .win_i        (fetch_win),
    .need_regs_i  (need_regids),
    .need_const_i (need_valC),
    .is_stack_i   (stack_op),
    .ra_o         (rA),
    .rb_o         (rB),
    .const_o      (valC)
  );

  fd_nextpc #(.ADDR_W(ADDR_W), .CONST_BYTES(CONST_BYTES)) u_nextpc (
    .pc_i         (pc_in),
    .valid_i      (instr_valid),
    .need_regs_i  (need_regids),
    .need_const_i (need_valC),
    .next_o       (valP)
  );

  always_comb begin
    if (!instr_valid)   stat = ST_INS;
    else if (halt_seen) stat = ST_HLT;
    else                stat = ST_AOK;
  end
endmodule

// File: rtl/fd_checker.sv
module fd_checker #(
  parameter int ADDR_W  = 64,
  parameter int CONST_W = 64
) (
  input logic [ADDR_W-1:0]  pc_in,
  input logic [3:0]         icode,
  input logic [3:0]         rA,
  input logic [3:0]         rB,
  input logic [CONST_W-1:0] valC,
  input logic [ADDR_W-1:0]  valP,
  input logic               need_regids,
  input logic               need_valC,
  input logic               instr_valid,
  input logic [2:0]         stat
);
  logic [ADDR_W-1:0] delta;
  assign delta = valP - pc_in;

  always_comb begin
    // R6: a legal instruction advances by one of the four lengths
    p_len_set_r6: assert (!instr_valid || delta == 1 || delta == 2 ||
                          delta == 9 || delta == 10);
    // R8: illegal encoding leaves no fields and no advance
    p_invalid_r8: assert (instr_valid ||
                          (rA == 4'hF && rB == 4'hF && valC == '0 && valP == pc_in));
    // R7: status is one of the three codes and tracks legality
    p_stat_r7: assert ((stat == 3'd4) == !instr_valid);
    // R4: absent register byte means both specifiers read 0xF
    p_regs_r4: assert (need_regids || (rA == 4'hF && rB == 4'hF));
    // R5: absent constant is zero
    p_const_r5: assert (need_valC || valC == '0);
    // R3: a constant without a register byte only for jump and call
    p_flags_r3: assert (!(need_valC && !need_regids) || icode == 4'h7 || icode == 4'h8);
  end
endmodule

bind fetch_decode fd_checker #(.ADDR_W(ADDR_W), .CONST_W(CONST_W)) u_chk (
  .pc_in       (pc_in),
  .icode       (icode),
  .rA          (rA),
  .rB          (rB),
  .valC        (valC),
  .valP        (valP),
  .need_regids (need_regids),
  .need_valC   (need_valC),
  .instr_valid (instr_valid),
  .stat        (stat)
);

// File: tb/sim_fetch_decode.sv
`timescale 1ns/1ps
module sim_fetch_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] pc_in;
  logic [79:0] fetch_win;
  logic [3:0]  icode, ifun, rA, rB;
  logic [63:0] valC, valP;
  logic        need_regids, need_valC, instr_valid;
  logic [2:0]  stat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fetch_decode u0 (
    .pc_in(pc_in), .fetch_win(fetch_win), .icode(icode), .ifun(ifun),
    .rA(rA), .rB(rB), .valC(valC), .valP(valP), .need_regids(need_regids),
    .need_valC(need_valC), .instr_valid(instr_valid), .stat(stat)
  );

  // Length in bytes per opcode; 0 means the opcode is not defined.
  function automatic int model_len(input logic [3:0] op);
    case (op)
      4'h0, 4'h1, 4'h9:       return 1;
      4'h2, 4'h6, 4'hA, 4'hB: return 2;
      4'h7, 4'h8:             return 9;
      4'h3, 4'h4, 4'h5:       return 10;
      default:                return 0;
    endcase
  endfunction

  function automatic bit model_ok(input logic [3:0] op, input logic [3:0] fn);
    if (model_len(op) == 0) return 1'b0;
    if (op == 4'h2 || op == 4'h7) return fn < 7;
    if (op == 4'h6) return fn < 4;
    return fn == 0;
  endfunction

  task automatic check64(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s win=%h pc=%h got=%h exp=%h", req, fetch_win, pc_in, got, exp);
    end
  endtask

  task automatic apply_and_check(input logic [63:0] pc, input logic [79:0] win);
    logic [3:0]  op, fn, eA, eB;
    int          len;
    bit          ok, er, ec;
    logic [63:0] ev, ep;
    logic [2:0]  es;
    @(posedge clk);
    #1;
    pc_in = pc;
    fetch_win = win;
    op = win[7:4];
    fn = win[3:0];
    len = model_len(op);
    ok = model_ok(op, fn);
    er = ok && (len == 2 || len == 10);
    ec = ok && (len >= 9);
    eA = er ? win[15:12] : 4'hF;
    eB = (er && op != 4'hA && op != 4'hB) ? win[11:8] : 4'hF;
    ev = '0;
    if (ec)
      for (int k = 7; k >= 0; k--) ev = (ev << 8) | 64'(win[8*(k + len - 8) +: 8]);
    ep = ok ? pc + 64'(len) : pc;
    es = !ok ? 3'd4 : (op == 4'h0 ? 3'd2 : 3'd1);
    @(negedge clk);
    check64("R1 icode", 64'(icode), 64'(op));
    check64("R1 ifun", 64'(ifun), 64'(fn));
    check64("R2 instr_valid", 64'(instr_valid), 64'(ok));
    check64("R3 need_regids", 64'(need_regids), 64'(er));
    check64("R3 need_valC", 64'(need_valC), 64'(ec));
    check64("R4 rA", 64'(rA), 64'(eA));
    check64("R4 rB", 64'(rB), 64'(eB));
    check64("R5 valC", valC, ev);
    check64("R6 valP", valP, ep);
    check64("R7 stat", 64'(stat), 64'(es));
    if (!ok) check64("R8 invalid valP", valP, pc);
  endtask

  initial begin
    logic [79:0] w;
    logic [63:0] pcs [3];
    logic [7:0]  rbytes [3];
    pcs[0] = 64'h0; pcs[1] = 64'h0000_0000_0000_1000; pcs[2] = 64'hFFFF_FFFF_FFFF_FFFA;
    rbytes[0] = 8'h37; rbytes[1] = 8'hF2; rbytes[2] = 8'hAB;
    pc_in = '0;
    fetch_win = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Initial state: an all-zero window is a halt (R7) of length 1 (R6)
    check64("R7 initial stat", 64'(stat), 64'd2);
    check64("R6 initial valP", valP, 64'd1);
    // Fixed little-endian constant: irmovq with known bytes (R5)
    apply_and_check(64'h100, {64'h0123_4567_89AB_CDEF, 8'hF3, 8'h30});
    check64("R5 irmovq constant", valC, 64'h0123_4567_89AB_CDEF);
    // Call across the top of the address space wraps (R6)
    apply_and_check(64'hFFFF_FFFF_FFFF_FFFC, {8'h00, 64'h1122_3344_5566_7788, 8'h80});
    check64("R6 wrap valP", valP, 64'h0000_0000_0000_0005);
    // Sweep of every first byte with several register bytes, constants and PCs
    for (int b = 0; b < 256; b++) begin
      for (int p = 0; p < 3; p++) begin
        w = '0;
        w[7:0] = 8'(b);
        w[15:8] = rbytes[p];
        for (int k = 2; k < 10; k++) w[8*k +: 8] = 8'((k * 37 + p * 91 + b) & 255);
        apply_and_check(pcs[p], w);
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 got=hung exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule